// File: doc/BRIEF.md
# Serial port register and interrupt block

This block holds the software-visible state of a FIFO-based serial port. A simple single-cycle bus accesses byte registers by offset. The registers cover line mode, baud divisor, control, port pins, FIFO control, a status word, receive data and receive count. Read data is combinational on the same cycle as the read strobe. All register state changes on the next clock edge.

The status word holds five event flags. Hardware sets them: the transmit side, the receive FIFO's full and ready indications, and a break strobe. Software clears a flag by writing 0 to its bit. The block drives a level transmit interrupt and a sticky receive interrupt. It emits a one-cycle transmit strobe carrying the byte written to the transmit data register. It also emits a pop strobe when software takes a byte from the receive FIFO. The baud generator, the shift registers and the FIFO storage are outside this block.

Top module: `sio_ctrl_regs`

## Requirements
- R1: After reset the status reads 0x60, control reads 0x20, rate reads 0xFF, and mode, port and FIFO control read 0. Both interrupts are low and the receive trigger level is 1.
- R2: Register offsets are mode 0x00, rate 0x04, control 0x08, transmit data 0x0C, status 0x10, receive data 0x14, FIFO control 0x18, receive count 0x1C, port 0x20 and line status 0x24. Stored writes are masked: mode with 0x7B, control with 0xFA, port with 0xF3. Rate and FIFO control keep all 8 bits. A readback returns the stored value.
- R3: Status bits are 6 transmit-end, 5 transmit-empty, 4 break, 1 receive-full and 0 data-ready, and the other bits read 0. Writing 0 to a flag bit clears the flag and writing 1 leaves it as it was.
- R4: A status read while control bit 5 is set returns the current flags and sets bits 6 and 5 on the next cycle. A status read with control bit 5 clear changes nothing.
- R5: A write to offset 0x0C raises tx_strobe for exactly one cycle, on the cycle after the write, with tx_byte equal to the written byte. The same write clears transmit-empty.
- R6: A control write with bit 5 clear sets transmit-end. tx_irq always equals stored control bit 7.
- R7: rx_irq rises on the cycle after rx_full_in is high while control bits 6 and 4 are both set. It falls after a status write with bit 1 or bit 0 at 0, or after a control write with bit 6 at 0.
- R8: rx_enable equals control bit 4. rx_full_in sets status bit 1 and rx_ready_in sets status bit 0 only while control bit 4 is set. break_pulse sets status bit 4 regardless of control bit 4.
- R9: A read of offset 0x14 returns rx_data_in and raises rx_pop in the same cycle when rx_count_in is nonzero. When the count is 0 it returns 0 with no pop.
- R10: Offset 0x1C reads rx_count_in zero-extended. Offsets 0x0C and 0x24, and every offset not listed in R2, read 0 and raise no error.
- R11: FIFO control bits 7:6 select rx_trigger as 1, 4, 8 or 14 for codes 0 to 3. A FIFO control write with bit 1 set raises fifo_clear for one cycle on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 6 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (ignored when bus_wr is high) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the strobe cycle |
| rx_data_in | input | 8 | Byte at the head of the receive FIFO |
| rx_count_in | input | 5 | Receive FIFO occupancy |
| rx_full_in | input | 1 | Receive FIFO reached its trigger level |
| rx_ready_in | input | 1 | Receive data waiting indication |
| break_pulse | input | 1 | Line break detected |
| rx_pop | output | 1 | Take one byte from the receive FIFO |
| rx_enable | output | 1 | Receiver enabled |
| rx_trigger | output | 5 | Receive FIFO trigger level |
| fifo_clear | output | 1 | One-cycle FIFO reset request |
| tx_strobe | output | 1 | Transmit byte valid |
| tx_byte | output | 8 | Byte to transmit |
| tx_irq | output | 1 | Transmit interrupt |
| rx_irq | output | 1 | Receive interrupt |
| cfg_mode | output | 8 | Line mode register |
| cfg_rate | output | 8 | Baud divisor register |
| cfg_port | output | 8 | Port pin register |

## Verification
The bench sweeps all 256 write values through every masked register and through the status register. A wrong mask shows up as a readback carrying a bit that should be stuck at 0. An inverted clear sense either keeps flags that software asked to drop or wipes flags it asked to keep.

The re-arm-on-read rule is checked in both control states. A design that re-arms without looking at control bit 5 reports transmit-empty again after a byte was written. A design that updates the flags before returning them hides the cleared state from software.

The receive interrupt is driven through each of its three clear paths and through its two gating bits. A missing gate raises rx_irq with the receiver off.

The receive data and count offsets are swept over every occupancy. A pop at count 0 would underflow the FIFO.

// File: rtl/sio_regs_pkg.sv
package sio_regs_pkg;

  localparam logic [7:0] OFS_MODE  = 8'h00;
  localparam logic [7:0] OFS_RATE  = 8'h04;
  localparam logic [7:0] OFS_CTRL  = 8'h08;
  localparam logic [7:0] OFS_TXD   = 8'h0C;
  localparam logic [7:0] OFS_STAT  = 8'h10;
  localparam logic [7:0] OFS_RXD   = 8'h14;
  localparam logic [7:0] OFS_FCTL  = 8'h18;
  localparam logic [7:0] OFS_RCNT  = 8'h1C;
  localparam logic [7:0] OFS_PORT  = 8'h20;
  localparam logic [7:0] OFS_LSTAT = 8'h24;

  localparam int CTL_TXIRQ = 7;
  localparam int CTL_RXIRQ = 6;
  localparam int CTL_TXEN  = 5;
  localparam int CTL_RXEN  = 4;

  localparam int FCTL_CLR = 1;

  typedef struct packed {
    logic tx_end;
    logic tx_empty;
    logic brk;
    logic rx_full;
    logic rx_ready;
  } stat_flags_t;

  // Place the flags at their status word bit positions.
  function automatic logic [7:0] status_byte(stat_flags_t f);
    return {1'b0, f.tx_end, f.tx_empty, f.brk, 2'b00, f.rx_full, f.rx_ready};
  endfunction

  // Pick out the flag bits of a status write (1 = keep, 0 = clear).
  function automatic stat_flags_t status_keep(logic [7:0] w);
    stat_flags_t k;
    k.tx_end   = w[6];
    k.tx_empty = w[5];
    k.brk      = w[4];
    k.rx_full  = w[1];
    k.rx_ready = w[0];
    return k;
  endfunction

  // Receive trigger level selected by FIFO control bits 7:6.
  function automatic logic [4:0] trig_level(logic [1:0] sel);
    logic [4:0] lvl;
    case (sel)
      2'd0:    lvl = 5'd1;
      2'd1:    lvl = 5'd4;
      2'd2:    lvl = 5'd8;
      default: lvl = 5'd14;
    endcase
    return lvl;
  endfunction

endpackage

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
  import sio_regs_pkg::*;
#(
  parameter int              DATA_W    = 8,
  parameter logic [DATA_W-1:0] MODE_MASK = 8'h7B,
  parameter logic [DATA_W-1:0] CTRL_MASK = 8'hFA,
  parameter logic [DATA_W-1:0] PORT_MASK = 8'hF3,
  parameter logic [DATA_W-1:0] CTRL_RST  = 8'h20,
  parameter logic [DATA_W-1:0] RATE_RST  = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_mode,
  input  logic              wr_rate,
  input  logic              wr_ctrl,
  input  logic              wr_port,
  input  logic              wr_fctl,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] mode_q,
  output logic [DATA_W-1:0] rate_q,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] port_q,
  output logic [DATA_W-1:0] fctl_q,
  output logic              fifo_clear
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= '0;
      rate_q     <= RATE_RST;
      ctrl_q     <= CTRL_RST;
      port_q     <= '0;
      fctl_q     <= '0;
      fifo_clear <= 1'b0;
    end else begin
      if (wr_mode) mode_q <= wdata & MODE_MASK;
      if (wr_rate) rate_q <= wdata;
      if (wr_ctrl) ctrl_q <= wdata & CTRL_MASK;
      if (wr_port) port_q <= wdata & PORT_MASK;
      if (wr_fctl) fctl_q <= wdata;
      fifo_clear <= wr_fctl & wdata[FCTL_CLR];
    end
  end

  // R2
  mode_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mode |=> mode_q == ($past(wdata) & MODE_MASK));
  // R2
  ctrl_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> ctrl_q == ($past(wdata) & CTRL_MASK));
  // R2
  port_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_port |=> port_q == ($past(wdata) & PORT_MASK));
  // R11
  fifo_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clear |-> $past(wr_fctl));

endmodule

// File: rtl/sio_status_flags.sv
module sio_status_flags
  import sio_regs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_stat,
  input  stat_flags_t keep,
  input  logic        ctrl_tx_off,
  input  logic        wr_txd,
  input  logic        rd_stat,
  input  logic        tx_en,
  input  logic        rx_en,
  input  logic        rx_full_in,
  input  logic        rx_ready_in,
  input  logic        break_pulse,
  output stat_flags_t flags
);

  logic rearm;
  logic full_set;
  logic ready_set;
  stat_flags_t drop;

  assign rearm     = rd_stat & tx_en;
  assign full_set  = rx_en & rx_full_in;
  assign ready_set = rx_en & rx_ready_in;
  assign drop      = wr_stat ? ~keep : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags          <= '0;
      flags.tx_end   <= 1'b1;
      flags.tx_empty <= 1'b1;
    end else begin
      if (ctrl_tx_off || rearm)  flags.tx_end <= 1'b1;
      else if (drop.tx_end)      flags.tx_end <= 1'b0;

      if (rearm)                            flags.tx_empty <= 1'b1;
      else if (wr_txd || drop.tx_empty)     flags.tx_empty <= 1'b0;

      if (break_pulse)      flags.brk <= 1'b1;
      else if (drop.brk)    flags.brk <= 1'b0;

      if (full_set)           flags.rx_full <= 1'b1;
      else if (drop.rx_full)  flags.rx_full <= 1'b0;

      if (ready_set)          flags.rx_ready <= 1'b1;
      else if (drop.rx_ready) flags.rx_ready <= 1'b0;
    end
  end

  // R5
  tx_empty_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_txd |=> !flags.tx_empty);
  // R4
  rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat && tx_en |=> flags.tx_end && flags.tx_empty);
  // R8
  rx_full_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags.rx_full) |-> $past(rx_en && rx_full_in));
  // R3
  keep_brk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags.brk && wr_stat && keep.brk |=> flags.brk);

endmodule

// File: rtl/sio_irq_ctrl.sv
module sio_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_en,
  input  logic rx_irq_en,
  input  logic tx_irq_en,
  input  logic rx_full_in,
  input  logic stat_rx_drop,
  input  logic ctrl_rx_off,
  output logic tx_irq,
  output logic rx_irq
);

  logic rx_raise;
  logic rx_lower;

  assign rx_raise = rx_en & rx_irq_en & rx_full_in;
  assign rx_lower = stat_rx_drop | ctrl_rx_off;
  assign tx_irq   = tx_irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rx_irq <= 1'b0;
    else if (rx_raise)  rx_irq <= 1'b1;
    else if (rx_lower)  rx_irq <= 1'b0;
  end

  // R7
  rx_irq_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_lower && !rx_raise |=> !rx_irq);
  // R7
  rx_irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_irq) |-> $past(rx_en && rx_irq_en && rx_full_in));

endmodule

// File: rtl/sio_tx_launch.sv
module sio_tx_launch #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_txd,
  input  logic [DATA_W-1:0] wdata,
  output logic              tx_strobe,
  output logic [DATA_W-1:0] tx_byte
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_strobe <= 1'b0;
      tx_byte   <= '0;
    end else begin
      tx_strobe <= wr_txd;
      if (wr_txd) tx_byte <= wdata;
    end
  end

  // R5
  tx_strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_strobe |-> $past(wr_txd));
  // R5
  tx_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_txd |=> tx_strobe && tx_byte == $past(wdata));

endmodule

// File: rtl/sio_ctrl_regs.sv
module sio_ctrl_regs
  import sio_regs_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] rx_data_in,
  input  logic [CNT_W-1:0]  rx_count_in,
  input  logic              rx_full_in,
  input  logic              rx_ready_in,
  input  logic              break_pulse,
  output logic              rx_pop,
  output logic              rx_enable,
  output logic [CNT_W-1:0]  rx_trigger,
  output logic              fifo_clear,
  output logic              tx_strobe,
  output logic [DATA_W-1:0] tx_byte,
  output logic              tx_irq,
  output logic              rx_irq,
  output logic [DATA_W-1:0] cfg_mode,
  output logic [DATA_W-1:0] cfg_rate,
  output logic [DATA_W-1:0] cfg_port
);

  localparam int PAD_W = DATA_W - CNT_W;

  logic rd_q;
  logic wr_mode, wr_rate, wr_ctrl, wr_txd, wr_stat, wr_fctl, wr_port;
  logic rd_stat, rd_rxd;
  logic [DATA_W-1:0] ctrl_q, fctl_q;
  logic ctrl_tx_off, ctrl_rx_off, stat_rx_drop;
  logic cnt_nonzero;
  stat_flags_t flags;
  stat_flags_t keep;

  function automatic logic hit(logic [ADDR_W-1:0] a, logic [7:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  // Write decode, reads masked off by a simultaneous write.
  assign rd_q    = bus_rd & ~bus_wr;
  assign wr_mode = bus_wr & hit(bus_addr, OFS_MODE);
  assign wr_rate = bus_wr & hit(bus_addr, OFS_RATE);
  assign wr_ctrl = bus_wr & hit(bus_addr, OFS_CTRL);
  assign wr_txd  = bus_wr & hit(bus_addr, OFS_TXD);
  assign wr_stat = bus_wr & hit(bus_addr, OFS_STAT);
  assign wr_fctl = bus_wr & hit(bus_addr, OFS_FCTL);
  assign wr_port = bus_wr & hit(bus_addr, OFS_PORT);
  assign rd_stat = rd_q & hit(bus_addr, OFS_STAT);
  assign rd_rxd  = rd_q & hit(bus_addr, OFS_RXD);

  assign keep         = status_keep(bus_wdata[7:0]);
  assign ctrl_tx_off  = wr_ctrl & ~bus_wdata[CTL_TXEN];
  assign ctrl_rx_off  = wr_ctrl & ~bus_wdata[CTL_RXIRQ];
  assign stat_rx_drop = wr_stat & ~(keep.rx_full & keep.rx_ready);
  assign cnt_nonzero  = |rx_count_in;
  assign rx_pop       = rd_rxd & cnt_nonzero;
  assign rx_enable    = ctrl_q[CTL_RXEN];
  assign rx_trigger   = CNT_W'(trig_level(fctl_q[7:6]));

  sio_cfg_regs #(.DATA_W(DATA_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_mode    (wr_mode),
    .wr_rate    (wr_rate),
    .wr_ctrl    (wr_ctrl),
    .wr_port    (wr_port),
    .wr_fctl    (wr_fctl),
    .wdata      (bus_wdata),
    .mode_q     (cfg_mode),
    .rate_q     (cfg_rate),
    .ctrl_q     (ctrl_q),
    .port_q     (cfg_port),
    .fctl_q     (fctl_q),
    .fifo_clear (fifo_clear)
  );

  sio_status_flags u_stat (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_stat     (wr_stat),
    .keep        (keep),
    .ctrl_tx_off (ctrl_tx_off),
    .wr_txd      (wr_txd),
    .rd_stat     (rd_stat),
    .tx_en       (ctrl_q[CTL_TXEN]),
    .rx_en       (ctrl_q[CTL_RXEN]),
    .rx_full_in  (rx_full_in),
    .rx_ready_in (rx_ready_in),
    .break_pulse (break_pulse),
    .flags       (flags)
  );

  sio_irq_ctrl u_irq (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_en        (ctrl_q[CTL_RXEN]),
    .rx_irq_en    (ctrl_q[CTL_RXIRQ]),
    .tx_irq_en    (ctrl_q[CTL_TXIRQ]),
    .rx_full_in   (rx_full_in),
    .stat_rx_drop (stat_rx_drop),
    .ctrl_rx_off  (ctrl_rx_off),
    .tx_irq       (tx_irq),
    .rx_irq       (rx_irq)
  );

  sio_tx_launch #(.DATA_W(DATA_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_txd    (wr_txd),
    .wdata     (bus_wdata),
    .tx_strobe (tx_strobe),
    .tx_byte   (tx_byte)
  );

  // Read mux: every offset that is not decoded returns 0.
  always_comb begin
    bus_rdata = '0;
    if (rd_q) begin
      if (hit(bus_addr, OFS_MODE))      bus_rdata = cfg_mode;
      else if (hit(bus_addr, OFS_RATE)) bus_rdata = cfg_rate;
      else if (hit(bus_addr, OFS_CTRL)) bus_rdata = ctrl_q;
      else if (hit(bus_addr, OFS_STAT)) bus_rdata = DATA_W'(status_byte(flags));
      else if (hit(bus_addr, OFS_RXD))  bus_rdata = cnt_nonzero ? rx_data_in : '0;
      else if (hit(bus_addr, OFS_FCTL)) bus_rdata = fctl_q;
      else if (hit(bus_addr, OFS_RCNT)) bus_rdata = {{PAD_W{1'b0}}, rx_count_in};
      else if (hit(bus_addr, OFS_PORT)) bus_rdata = cfg_port;
    end
  end

  // R9
  no_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> rx_count_in != '0);
  // R10
  lstat_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_q && hit(bus_addr, OFS_LSTAT) |-> bus_rdata == '0);

endmodule

// File: tb/sio_ctrl_regs_test.sv
module sio_ctrl_regs_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] rx_data_in = '0;
  logic [4:0] rx_count_in = '0;
  logic       rx_full_in = 1'b0;
  logic       rx_ready_in = 1'b0;
  logic       break_pulse = 1'b0;
  logic       rx_pop, rx_enable, fifo_clear, tx_strobe, tx_irq, rx_irq;
  logic [4:0] rx_trigger;
  logic [7:0] tx_byte, cfg_mode, cfg_rate, cfg_port;

  int n_vec = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  sio_ctrl_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_data_in(rx_data_in), .rx_count_in(rx_count_in),
    .rx_full_in(rx_full_in), .rx_ready_in(rx_ready_in),
    .break_pulse(break_pulse), .rx_pop(rx_pop), .rx_enable(rx_enable),
    .rx_trigger(rx_trigger), .fifo_clear(fifo_clear),
    .tx_strobe(tx_strobe), .tx_byte(tx_byte), .tx_irq(tx_irq),
    .rx_irq(rx_irq), .cfg_mode(cfg_mode), .cfg_rate(cfg_rate),
    .cfg_port(cfg_port)
  );

  task automatic check(input string tag, input int got, input int exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d, output logic pop);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    d = bus_rdata; pop = rx_pop;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse_rx(input logic full, input logic ready, input logic brk);
    @(negedge clk);
    rx_full_in = full; rx_ready_in = ready; break_pulse = brk;
    @(negedge clk);
    rx_full_in = 1'b0; rx_ready_in = 1'b0; break_pulse = 1'b0;
  endtask

  function automatic int trig_of(int code);
    if (code == 0) return 1;
    if (code == 3) return 14;
    return 4 * code;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 tx_irq", tx_irq, 0);
    check("R1 rx_irq", rx_irq, 0);
    check("R1 trigger", rx_trigger, 1);
    rd(6'h10, d, p); check("R1 status", d, 8'h60);
    rd(6'h08, d, p); check("R1 control", d, 8'h20);
    rd(6'h04, d, p); check("R1 rate", d, 8'hFF);
    rd(6'h00, d, p); check("R1 mode", d, 0);
    rd(6'h20, d, p); check("R1 port", d, 0);
    rd(6'h18, d, p); check("R1 fifo ctrl", d, 0);

    // R2 masked register sweeps, R11 FIFO control
    for (int v = 0; v < 256; v++) begin
      wr(6'h00, 8'(v)); rd(6'h00, d, p); check("R2 mode", d, v & 8'h7B);
      check("R2 cfg_mode", cfg_mode, v & 8'h7B);
      wr(6'h04, 8'(v)); rd(6'h04, d, p); check("R2 rate", d, v);
      wr(6'h20, 8'(v)); rd(6'h20, d, p); check("R2 port", d, v & 8'hF3);
      check("R2 cfg_port", cfg_port, v & 8'hF3);
      wr(6'h18, 8'(v));
      check("R11 fifo_clear", fifo_clear, (v >> 1) & 1);
      rd(6'h18, d, p); check("R2 fifo ctrl", d, v);
      check("R11 fifo_clear one cycle", fifo_clear, 0);
      check("R11 trigger", rx_trigger, trig_of(v >> 6));
    end

    // R6 control sweep: tx-end set by bit 5 clear, tx_irq follows bit 7
    for (int v = 0; v < 256; v++) begin
      wr(6'h10, 8'hBF);
      wr(6'h08, 8'(v));
      rd(6'h08, d, p); check("R2 control", d, v & 8'hFA);
      check("R6 tx_irq", tx_irq, (v >> 7) & 1);
      check("R8 rx_enable", rx_enable, (v >> 4) & 1);
      rd(6'h10, d, p);
      check("R6 tx_end", (d >> 6) & 1, ((v >> 5) & 1) ? 0 : 1);
    end

    // R3 status write-zero-to-clear sweep
    wr(6'h08, 8'h30);
    for (int v = 0; v < 256; v++) begin
      pulse_rx(1'b1, 1'b1, 1'b1);
      rd(6'h10, d, p);
      rd(6'h10, d, p); check("R3 all set", d, 8'h73);
      wr(6'h10, 8'(v));
      rd(6'h10, d, p); check("R3 cleared", d, v & 8'h73);
    end

    // R8 receive gating and break
    wr(6'h08, 8'h20);
    wr(6'h10, 8'h00);
    pulse_rx(1'b1, 1'b1, 1'b0);
    rd(6'h10, d, p); check("R8 gated rx flags", d, 8'h00);
    pulse_rx(1'b0, 1'b0, 1'b1);
    rd(6'h10, d, p); check("R8 break ungated", d, 8'h70);

    // R4/R5 transmit data and re-arm
    for (int v = 0; v < 256; v++) begin
      wr(6'h0C, 8'(v));
      check("R5 tx_strobe", tx_strobe, 1);
      check("R5 tx_byte", tx_byte, v);
      rd(6'h10, d, p);
      check("R5 tx_empty cleared", (d >> 5) & 1, 0);
      check("R5 strobe single", tx_strobe, 0);
      rd(6'h10, d, p);
      check("R4 rearm", d & 8'h60, 8'h60);
    end
    wr(6'h08, 8'h00);
    wr(6'h0C, 8'h5A);
    rd(6'h10, d, p);
    rd(6'h10, d, p);
    check("R4 no rearm when tx off", (d >> 5) & 1, 0);

    // R7 receive interrupt
    wr(6'h08, 8'h70);
    wr(6'h10, 8'h00);
    pulse_rx(1'b1, 1'b0, 1'b0); check("R7 rise", rx_irq, 1);
    wr(6'h10, 8'hFD);          check("R7 clear by bit1", rx_irq, 0);
    pulse_rx(1'b1, 1'b0, 1'b0); check("R7 rise again", rx_irq, 1);
    wr(6'h10, 8'hFE);          check("R7 clear by bit0", rx_irq, 0);
    pulse_rx(1'b1, 1'b0, 1'b0);
    wr(6'h10, 8'hFF);          check("R7 all-ones keeps", rx_irq, 1);
    wr(6'h08, 8'h30);          check("R7 clear by control", rx_irq, 0);
    pulse_rx(1'b1, 1'b0, 1'b0); check("R7 needs bit6", rx_irq, 0);
    wr(6'h08, 8'h60);
    pulse_rx(1'b1, 1'b0, 1'b0); check("R7 needs bit4", rx_irq, 0);

    // R9/R10 receive data and count
    for (int c = 0; c < 32; c++) begin
      rx_count_in = 5'(c);
      rx_data_in = 8'(c * 7 + 3);
      rd(6'h1C, d, p); check("R10 count", d, c);
      check("R10 count no pop", p, 0);
      rd(6'h14, d, p);
      check("R9 rx data", d, (c != 0) ? (c * 7 + 3) & 8'hFF : 0);
      check("R9 pop", p, (c != 0) ? 1 : 0);
    end
    wr(6'h1C, 8'hFF);
    rd(6'h1C, d, p); check("R10 count write ignored", d, 31);
    rx_count_in = '0;

    // R10 undecoded offsets read 0
    for (int a = 0; a < 64; a++) begin
      if (a == 8'h00 || a == 8'h04 || a == 8'h08 || a == 8'h10 ||
          a == 8'h14 || a == 8'h18 || a == 8'h1C || a == 8'h20) continue;
      rd(6'(a), d, p); check("R10 undecoded", d, 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule